// File: doc/BRIEF.md
# Logic Analyzer Acquisition Sequencer

This block runs one capture cycle of a small logic analyzer. A host talks to it through write strobes that carry an address and data. Three of the addresses are commands: arm the capture, start reading back the capture memory, and end that readback by hand. Two more addresses load a qualifier mask register and a qualifier polarity register.

While capture is armed, the block compares the external qualifier lines against the programmed pattern on every system clock. Polarity is applied to each line first, and masked lines are then forced to "don't care". The surviving terms are ANDed into a single qualify term, which is gated by the armed state. The block registers a trigger-qualify enable and a clock-qualify enable on every clock edge.

Capture ends when the capture memory raises its full flag. A readback command then starts the readback phase, and during that phase the block drives the enable that advances the memory address counter. A manual stop command returns the block to idle.

Top module: `acq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle. After that edge, `state_o` is 2'b00, all enables are low, and the mask and polarity registers hold zero.
- R2: A host write to the arm address (0x56) while idle moves `state_o` to acquiring (2'b01) at that clock edge.
- R3: Arm and readback commands are ignored in any state other than idle, and manual stop is ignored outside readback. The state does not change.
- R4: While acquiring, a high `mem_full` at a clock edge returns the block to idle (2'b00) at that edge.
- R5: A host write to the readback address (0x55) while idle moves `state_o` to readback (2'b10). `addr_adv_en` is high exactly while `state_o` is 2'b10.
- R6: A host write to the manual-stop address (0x53) during readback returns the block to idle and drops `addr_adv_en` at that edge.
- R7: A mask bit of 1 (register written at address 0x50, bit i applies to `qual_in[i]`) makes qualifier bit i "don't care", whatever its polarity bit.
- R8: Polarity bit i (register written at address 0x51) selects the matching level of unmasked `qual_in[i]`: 0 matches high and 1 matches low.
- R9: At each clock edge, `trig_qual_q` is loaded with 1 only when the state before that edge was acquiring and every qualifier bit matched at that edge. Otherwise it is loaded with 0.
- R10: At each clock edge, `clk_qual_q` is loaded with 1 exactly when the state before that edge was acquiring.
- R11: A write to the mask or polarity register is first used for qualification at the clock edge after the one that stored it.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_addr | input | 8 | Host I/O address |
| host_wdata | input | 8 | Host write data for the mask and polarity registers |
| qual_in | input | 8 | External qualifier lines |
| mem_full | input | 1 | Stop flag from the capture memory |
| trig_qual_q | output | 1 | Registered trigger-qualify enable |
| clk_qual_q | output | 1 | Registered clock-qualify enable |
| addr_adv_en | output | 1 | Enable that advances the memory address counter |
| state_o | output | 2 | 00 idle, 01 acquiring, 10 readback |

## Verification
The bench tests the masked-bit case with its polarity bit set. A design that applied polarity after the mask would never qualify in that case. It writes the mask in the middle of an acquisition, to catch a design that uses the new mask in the same cycle it is stored. It sends arm and readback commands while busy, where a design that accepts them would jump states or restart the address enable. It also raises `mem_full` and manual stop in the wrong states: a design that reacts to them would leave acquiring or readback too early, or fall back to idle when it should stay put.

// File: rtl/acqc_pkg.sv
package acqc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ACQ  = 2'b01,
        ST_READ = 2'b10
    } acq_state_e;

    typedef struct packed {
        logic arm;
        logic readback;
        logic halt;
        logic load_mask;
        logic load_pol;
    } host_cmd_t;

    function automatic acq_state_e next_state(input acq_state_e cur,
                                              input host_cmd_t cmd,
                                              input logic full);
        acq_state_e nxt;
        nxt = cur;
        unique case (cur)
            ST_IDLE: begin
                if (cmd.arm)           nxt = ST_ACQ;
                else if (cmd.readback) nxt = ST_READ;
            end
            ST_ACQ:  if (full)     nxt = ST_IDLE;
            ST_READ: if (cmd.halt) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/acqc_cmd_decode.sv
module acqc_cmd_decode
    import acqc_pkg::*;
#(
    parameter int          AW        = 8,
    parameter logic [AW-1:0] ARM_ADDR  = 8'h56,
    parameter logic [AW-1:0] READ_ADDR = 8'h55,
    parameter logic [AW-1:0] HALT_ADDR = 8'h53,
    parameter logic [AW-1:0] MASK_ADDR = 8'h50,
    parameter logic [AW-1:0] POL_ADDR  = 8'h51
) (
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output host_cmd_t     cmd
);
    always_comb begin
        cmd           = '0;
        cmd.arm       = wr && (addr == ARM_ADDR);
        cmd.readback  = wr && (addr == READ_ADDR);
        cmd.halt      = wr && (addr == HALT_ADDR);
        cmd.load_mask = wr && (addr == MASK_ADDR);
        cmd.load_pol  = wr && (addr == POL_ADDR);
    end
endmodule

// File: rtl/acqc_sequencer.sv
module acqc_sequencer
    import acqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  host_cmd_t  cmd,
    input  logic       full,
    output acq_state_e state
);
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= next_state(state, cmd, full);
    end
endmodule

// File: rtl/acqc_qualify.sv
module acqc_qualify
    import acqc_pkg::*;
#(
    parameter int QW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  host_cmd_t     cmd,
    input  logic [QW-1:0] wdata,
    input  logic [QW-1:0] qual,
    input  acq_state_e    state,
    output logic          trig_q,
    output logic          clkq_q
);
    logic [QW-1:0] mask_r;
    logic [QW-1:0] pol_r;
    logic [QW-1:0] term;
    logic          all_hit;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_r <= '0;
            pol_r  <= '0;
        end else begin
            if (cmd.load_mask) mask_r <= wdata;
            if (cmd.load_pol)  pol_r  <= wdata;
        end
    end

    // polarity first, then mask forces the bit true
    for (genvar i = 0; i < QW; i++) begin : g_bit
        assign term[i] = (qual[i] ^ pol_r[i]) | mask_r[i];
    end

    assign all_hit = &term;
    assign armed   = (state == ST_ACQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
            clkq_q <= 1'b0;
        end else begin
            trig_q <= armed & all_hit;
            clkq_q <= armed;
        end
    end
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
    import acqc_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            QW        = 8,
    parameter logic [AW-1:0] ARM_ADDR  = 8'h56,
    parameter logic [AW-1:0] READ_ADDR = 8'h55,
    parameter logic [AW-1:0] HALT_ADDR = 8'h53,
    parameter logic [AW-1:0] MASK_ADDR = 8'h50,
    parameter logic [AW-1:0] POL_ADDR  = 8'h51
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [QW-1:0] host_wdata,
    input  logic [QW-1:0] qual_in,
    input  logic          mem_full,
    output logic          trig_qual_q,
    output logic          clk_qual_q,
    output logic          addr_adv_en,
    output logic [1:0]    state_o
);
    host_cmd_t  cmd;
    acq_state_e state;

    acqc_cmd_decode #(
        .AW(AW), .ARM_ADDR(ARM_ADDR), .READ_ADDR(READ_ADDR),
        .HALT_ADDR(HALT_ADDR), .MASK_ADDR(MASK_ADDR), .POL_ADDR(POL_ADDR)
    ) dec_i (
        .wr   (host_wr),
        .addr (host_addr),
        .cmd  (cmd)
    );

    acqc_sequencer seq_i (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .full  (mem_full),
        .state (state)
    );

    acqc_qualify #(.QW(QW)) qual_i (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .wdata  (host_wdata),
        .qual   (qual_in),
        .state  (state),
        .trig_q (trig_qual_q),
        .clkq_q (clk_qual_q)
    );

    assign addr_adv_en = (state == ST_READ);
    assign state_o     = state;
endmodule

// File: rtl/acq_ctrl_chk.sv
module acq_ctrl_chk #(
    parameter int            AW        = 8,
    parameter logic [AW-1:0] ARM_ADDR  = 8'h56,
    parameter logic [AW-1:0] READ_ADDR = 8'h55,
    parameter logic [AW-1:0] HALT_ADDR = 8'h53
) (
    input logic          clk,
    input logic          rst,
    input logic          host_wr,
    input logic [AW-1:0] host_addr,
    input logic          mem_full,
    input logic          trig_qual_q,
    input logic          clk_qual_q,
    input logic          addr_adv_en,
    input logic [1:0]    state_o
);
    p_arm_r2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00 && host_wr && host_addr == ARM_ADDR) |=> state_o == 2'b01);

    p_busy_ignore_r3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01 && !mem_full) |=> state_o == 2'b01);

    p_full_ends_r4: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01 && mem_full) |=> state_o == 2'b00);

    p_read_start_r5: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00 && host_wr && host_addr == READ_ADDR) |=> addr_adv_en);

    p_halt_r6: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b10 && host_wr && host_addr == HALT_ADDR) |=> (state_o == 2'b00 && !addr_adv_en));

    p_trig_gated_r9: assert property (@(posedge clk) disable iff (rst)
        (state_o != 2'b01) |=> !trig_qual_q);

    p_clkq_on_r10: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01) |=> clk_qual_q);

    p_clkq_off_r10: assert property (@(posedge clk) disable iff (rst)
        (state_o != 2'b01) |=> !clk_qual_q);

    p_legal_state_r1: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'b11);
endmodule

bind acq_ctrl acq_ctrl_chk #(
    .AW(AW), .ARM_ADDR(ARM_ADDR), .READ_ADDR(READ_ADDR), .HALT_ADDR(HALT_ADDR)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .mem_full    (mem_full),
    .trig_qual_q (trig_qual_q),
    .clk_qual_q  (clk_qual_q),
    .addr_adv_en (addr_adv_en),
    .state_o     (state_o)
);

// File: tb/acq_ctrl_tb_top.sv
module acq_ctrl_tb_top;
    localparam logic [7:0] A_ARM  = 8'h56;
    localparam logic [7:0] A_READ = 8'h55;
    localparam logic [7:0] A_HALT = 8'h53;
    localparam logic [7:0] A_MASK = 8'h50;
    localparam logic [7:0] A_POL  = 8'h51;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr;
    logic [7:0] host_addr;
    logic [7:0] host_wdata;
    logic [7:0] qual_in;
    logic       mem_full;
    logic       trig_qual_q, clk_qual_q, addr_adv_en;
    logic [1:0] state_o;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [1:0] m_st;
    logic [7:0] m_mask, m_pol;
    logic       m_trig, m_clkq;

    always #5 clk = ~clk;

    acq_ctrl dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .qual_in(qual_in), .mem_full(mem_full),
        .trig_qual_q(trig_qual_q), .clk_qual_q(clk_qual_q),
        .addr_adv_en(addr_adv_en), .state_o(state_o)
    );

    function automatic logic exp_match(input logic [7:0] q, input logic [7:0] m,
                                       input logic [7:0] p);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 8; i++)
            if (!m[i] && (q[i] == p[i])) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [1:0] exp_next(input logic [1:0] s, input logic wr,
                                            input logic [7:0] a, input logic full);
        case (s)
            2'b00: if (wr && a == A_ARM) return 2'b01;
                   else if (wr && a == A_READ) return 2'b10;
            2'b01: if (full) return 2'b00;
            2'b10: if (wr && a == A_HALT) return 2'b00;
            default: return 2'b00;
        endcase
        return s;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, "/R2"},  "state_o",     {6'd0, state_o},     {6'd0, m_st});
        chk({tag, "/R5"},  "addr_adv_en", {7'd0, addr_adv_en}, {7'd0, m_st == 2'b10});
        chk({tag, "/R9"},  "trig_qual_q", {7'd0, trig_qual_q}, {7'd0, m_trig});
        chk({tag, "/R10"}, "clk_qual_q",  {7'd0, clk_qual_q},  {7'd0, m_clkq});
    endtask

    task automatic cyc(input string tag, input logic wr, input logic [7:0] a,
                       input logic [7:0] d, input logic [7:0] q, input logic full);
        @(negedge clk);
        host_wr = wr; host_addr = a; host_wdata = d; qual_in = q; mem_full = full;
        @(posedge clk);
        m_trig = (m_st == 2'b01) && exp_match(q, m_mask, m_pol);
        m_clkq = (m_st == 2'b01);
        m_st   = exp_next(m_st, wr, a, full);
        if (wr && a == A_MASK) m_mask = d;
        if (wr && a == A_POL)  m_pol  = d;
        #1;
        compare_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; host_wr = 0; host_addr = 0; host_wdata = 0; qual_in = 0; mem_full = 0;
        @(posedge clk); @(posedge clk);
        #1;
        m_st = 2'b00; m_mask = '0; m_pol = '0; m_trig = 0; m_clkq = 0;
        compare_all("R1");
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        logic [7:0] a;
        int r;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1; host_wr = 0; host_addr = 0; host_wdata = 0; qual_in = 0; mem_full = 0;
        // R1 reset state after power-on
        do_reset();

        // R2 arm, then R9 all lines high match with zero mask/polarity
        cyc("R2", 1, A_ARM, 8'h00, 8'h00, 0);
        cyc("R9", 0, 8'h00, 8'h00, 8'hFF, 0);
        cyc("R9", 0, 8'h00, 8'h00, 8'hFE, 0);
        // R3 re-arm and readback while acquiring ignored
        cyc("R3", 1, A_ARM, 8'h00, 8'hFF, 0);
        cyc("R3", 1, A_READ, 8'h00, 8'hFF, 0);
        cyc("R3", 1, A_HALT, 8'h00, 8'hFF, 0);
        chk("R3", "state_o busy", {6'd0, state_o}, 8'h01);
        // R11 mask written mid-capture applies from the next edge
        cyc("R11", 1, A_MASK, 8'h0F, 8'h00, 0);
        cyc("R11", 0, 8'h00, 8'h00, 8'hF0, 0);
        chk("R11", "trig after mask", {7'd0, trig_qual_q}, 8'h01);
        // R7 masked bits don't care even with polarity set
        cyc("R7", 1, A_POL, 8'h0F, 8'hF0, 0);
        cyc("R7", 0, 8'h00, 8'h00, 8'hF3, 0);
        chk("R7", "masked with pol", {7'd0, trig_qual_q}, 8'h01);
        // R8 low-matching polarity on unmasked bits
        cyc("R8", 1, A_POL, 8'hF0, 8'hFF, 0);
        cyc("R8", 0, 8'h00, 8'h00, 8'h05, 0);
        chk("R8", "low match", {7'd0, trig_qual_q}, 8'h01);
        cyc("R8", 0, 8'h00, 8'h00, 8'h85, 0);
        chk("R8", "low miss", {7'd0, trig_qual_q}, 8'h00);
        // R4 memory full ends capture
        cyc("R4", 0, 8'h00, 8'h00, 8'h00, 1);
        chk("R4", "state_o idle", {6'd0, state_o}, 8'h00);
        cyc("R10", 0, 8'h00, 8'h00, 8'h00, 0);
        chk("R10", "clk_qual low", {7'd0, clk_qual_q}, 8'h00);
        // R5 readback start
        cyc("R5", 1, A_READ, 8'h00, 8'h00, 0);
        chk("R5", "addr_adv_en", {7'd0, addr_adv_en}, 8'h01);
        cyc("R3", 1, A_ARM, 8'h00, 8'h00, 1);
        chk("R3", "arm in readback", {6'd0, state_o}, 8'h02);
        // R6 manual stop
        cyc("R6", 1, A_HALT, 8'h00, 8'h00, 0);
        chk("R6", "addr_adv_en off", {7'd0, addr_adv_en}, 8'h00);
        cyc("R3", 1, A_HALT, 8'h00, 8'h00, 0);
        chk("R3", "halt in idle", {6'd0, state_o}, 8'h00);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            r = $urandom_range(0, 99);
            if (r < 6)       a = A_ARM;
            else if (r < 10) a = A_READ;
            else if (r < 15) a = A_HALT;
            else if (r < 20) a = A_MASK;
            else if (r < 25) a = A_POL;
            else             a = 8'($urandom_range(0, 255));
            cyc("rand", ($urandom_range(0, 3) == 0), a, 8'($urandom),
                ($urandom_range(0, 1) == 0) ? 8'hFF : 8'($urandom),
                ($urandom_range(0, 19) == 0));
            if (n == 2000) do_reset();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule